// File: doc/BRIEF.md
# Asynchronous SRAM Functional Tester

This block is a clocked sequencer that exercises a 2K x 8 asynchronous static RAM through its pins and judges what the part returns. It drives active-low chip, output and write enables and an 11-bit address. It also drives the data bus through a split output, an enable and an input, so that the pad tristate sits outside the block. A one-cycle start pulse runs a fixed program of four phases. First comes a per-line check on every data bit. Next, twelve thermometer-coded addresses are filled and read back. A check follows that a write is blocked while chip enable is high. The last phase checks that the bus floats high while output enable is high.

Every pin step lasts `STEP_CYCLES` clocks, so the RAM's access time and write-pulse width can be met at the system clock rate. The first miscompare halts the program. The tester then holds `done` and `fail` high, together with a phase code and the address that failed. A clean run ends with `done` high and `fail` low. The next accepted start clears all results.

Top module: `sram_tester`

## Requirements
- R1: Outside a run the pins rest at chip enable low, output enable low, write enable high, address zero and data driver off. After reset `done` and `fail` are low.
- R2: A write presents the address, lowers write enable, then drives the data, then raises write enable while the data is still driven, and releases the driver only in the following step.
- R3: A read presents the address and samples the bus at the end of its second step with the driver off and write enable high. It compares only the bits set in that read's mask.
- R4: Phase code 1 visits data lines D0 to D7 in order at address 0. For each line it writes 0, reads it back, writes 1 and reads it back, comparing only that bit. A read-path stuck-at-1 on line k therefore fails after 2k+1 writes, and a stuck-at-0 after 2k+2.
- R5: Phase code 2 writes twelve pairs and then reads them back in the same order. Pair i (0..11) has address 2^i-1. Its data is 2^i-1 for i up to 8 and 0xFF shifted left by i-8 (truncated to 8 bits) above that.
- R6: Phase code 3 writes 0x55 to `CHK_ADDR` (default 0x03F). It then performs a full write of 0xAA with chip enable high, and reads back expecting 0x55 with chip enable low.
- R7: Phase code 4 writes 0x00 to `CHK_ADDR`, then reads it with output enable held high, and requires bit 0 to read 1 with the other bits ignored.
- R8: Every pin step lasts exactly `STEP_CYCLES` clocks (default 2). Each write-enable low pulse and each data-drive window is two steps long. A clean run takes (4 x writes + 2 x reads) x `STEP_CYCLES` clocks from the start edge.
- R9: On the first miscompare no further pin step is issued. `done` and `fail` rise on the next clock, and `fail_phase` and `fail_addr` hold the phase code and address of the failing read until the next start.
- R10: The data driver is enabled only while write enable is low or during the write hold step.
- R11: A run with no miscompare ends with `done` high, `fail` low and `fail_phase` zero, after 31 write pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches the test program when idle |
| ram_ce_n | output | 1 | Chip enable to the RAM, active low |
| ram_oe_n | output | 1 | Output enable to the RAM, active low |
| ram_we_n | output | 1 | Write enable to the RAM, active low |
| ram_addr | output | 11 | RAM address |
| ram_dq_out | output | 8 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Enables the data pad driver |
| ram_dq_in | input | 8 | Data seen on the RAM bus |
| done | output | 1 | Program finished or stopped |
| fail | output | 1 | A miscompare stopped the program |
| fail_phase | output | 3 | Phase code of the failing read, 0 on a clean run |
| fail_addr | output | 11 | Address of the failing read |

## Verification
The hardest outcomes to reach from the ports are the failure paths. A healthy RAM only ever produces a clean pass, and the chip-enable and output-enable phases are reached only after the first two phases have succeeded. The bench therefore places a behavioural RAM with fault knobs behind the pins. It sweeps a read-path stuck-at-0 and a stuck-at-1 over every data line and ignores each address bit in turn. It also adds a RAM that writes regardless of chip enable and one that drives regardless of output enable. For each fault the bench works out the failing phase, address and write count arithmetically.

// File: rtl/sram_tester_pkg.sv
package sram_tester_pkg;

  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;

  localparam int FILL_N = ADDR_W + 1;
  localparam int LINE_N = DATA_W * 4;
  localparam int CE_OPS = 3;
  localparam int OE_OPS = 2;
  localparam int MAX_OPS = (LINE_N > 2 * FILL_N) ? LINE_N : 2 * FILL_N;
  localparam int IDX_W = $clog2(MAX_OPS);

  localparam logic [DATA_W-1:0] D_ONES = {DATA_W{1'b1}};
  localparam logic [ADDR_W-1:0] A_ONES = {ADDR_W{1'b1}};
  localparam logic [DATA_W-1:0] D_ALT_LO = {(DATA_W/2){2'b01}};
  localparam logic [DATA_W-1:0] D_ALT_HI = {(DATA_W/2){2'b10}};

  typedef logic [2:0] phase_t;
  localparam phase_t PH_NONE = 3'd0;
  localparam phase_t PH_LINE = 3'd1;
  localparam phase_t PH_FILL = 3'd2;
  localparam phase_t PH_CE   = 3'd3;
  localparam phase_t PH_OE   = 3'd4;

  typedef struct packed {
    logic              wr;
    logic              ce_n;
    logic              oe_n;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] mask;
  } op_t;

  // thermometer address: i ones filled from the LSB
  function automatic logic [ADDR_W-1:0] therm_addr(int i);
    return A_ONES >> (ADDR_W - i);
  endfunction

  // rising thermometer up to all ones, then zeros shift in from the LSB
  function automatic logic [DATA_W-1:0] therm_data(int i);
    if (i <= DATA_W) return D_ONES >> (DATA_W - i);
    return D_ONES << (i - DATA_W);
  endfunction

  function automatic int ops_in_phase(phase_t ph);
    case (ph)
      PH_LINE: return LINE_N;
      PH_FILL: return 2 * FILL_N;
      PH_CE:   return CE_OPS;
      PH_OE:   return OE_OPS;
      default: return 1;
    endcase
  endfunction

  function automatic logic byte_miscompare(logic [DATA_W-1:0] got,
                                           logic [DATA_W-1:0] want,
                                           logic [DATA_W-1:0] mask);
    return |((got ^ want) & mask);
  endfunction

  function automatic op_t op_decode(phase_t ph, int idx, logic [ADDR_W-1:0] chk);
    op_t o;
    int  ln;
    int  sub;
    o      = '0;
    o.mask = D_ONES;
    case (ph)
      PH_LINE: begin
        ln     = idx / 4;
        sub    = idx % 4;
        o.wr   = (sub % 2) == 0;
        o.mask = DATA_W'(1) << ln;
        o.data = (sub >= 2) ? o.mask : '0;
      end
      PH_FILL: begin
        if (idx < FILL_N) begin
          o.wr   = 1'b1;
          o.addr = therm_addr(idx);
          o.data = therm_data(idx);
        end else begin
          o.addr = therm_addr(idx - FILL_N);
          o.data = therm_data(idx - FILL_N);
        end
      end
      PH_CE: begin
        o.addr = chk;
        case (idx)
          0:       begin o.wr = 1'b1; o.data = D_ALT_LO; end
          1:       begin o.wr = 1'b1; o.data = D_ALT_HI; o.ce_n = 1'b1; end
          default: begin o.data = D_ALT_LO; end
        endcase
      end
      PH_OE: begin
        o.addr = chk;
        if (idx == 0) begin
          o.wr = 1'b1;
        end else begin
          o.oe_n = 1'b1;
          o.data = DATA_W'(1);
          o.mask = DATA_W'(1);
        end
      end
      default: o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/sram_step_timer.sv
module sram_step_timer #(
  parameter int STEP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic step_last
);
  localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign step_last = run && (cnt_q == CNT_W'(STEP_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (clear || !run || step_last)  cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_tester_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CHK_ADDR = 11'h03F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step_last,
  input  logic              mismatch,
  output logic              running,
  output logic              start_ok,
  output phase_t            phase,
  output logic [1:0]        step,
  output logic              op_wr,
  output logic              op_ce_n,
  output logic              op_oe_n,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [DATA_W-1:0] op_mask,
  output logic              finish_ok
);
  logic             run_q;
  phase_t           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       step_q;
  op_t              op;
  logic [1:0]       last_step;
  logic             op_last;
  logic             op_end;

  assign op        = op_decode(phase_q, int'(idx_q), CHK_ADDR);
  assign last_step = op.wr ? 2'd3 : 2'd1;
  assign op_last   = int'(idx_q) == ops_in_phase(phase_q) - 1;
  assign op_end    = run_q && step_last && !mismatch && (step_q == last_step);
  assign finish_ok = op_end && op_last && (phase_q == PH_OE);
  assign start_ok  = start && !run_q;

  assign running = run_q;
  assign phase   = phase_q;
  assign step    = step_q;
  assign op_wr   = op.wr;
  assign op_ce_n = op.ce_n;
  assign op_oe_n = op.oe_n;
  assign op_addr = op.addr;
  assign op_data = op.data;
  assign op_mask = op.mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= PH_NONE;
      idx_q   <= '0;
      step_q  <= '0;
    end else if (start_ok) begin
      run_q   <= 1'b1;
      phase_q <= PH_LINE;
      idx_q   <= '0;
      step_q  <= '0;
    end else if (run_q && step_last) begin
      if (mismatch) begin
        run_q <= 1'b0;
      end else if (step_q == last_step) begin
        step_q <= '0;
        if (op_last) begin
          idx_q <= '0;
          if (phase_q == PH_OE) run_q <= 1'b0;
          else                  phase_q <= phase_q + 3'd1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else begin
        step_q <= step_q + 2'd1;
      end
    end
  end
endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_tester_pkg::*;
(
  input  logic              running,
  input  logic [1:0]        step,
  input  logic              op_wr,
  input  logic              op_ce_n,
  input  logic              op_oe_n,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              hold_step,
  output logic              sample_step
);
  always_comb begin
    ce_n        = 1'b0;
    oe_n        = 1'b0;
    we_n        = 1'b1;
    addr        = '0;
    dq_out      = '0;
    dq_oe       = 1'b0;
    hold_step   = 1'b0;
    sample_step = 1'b0;
    if (running) begin
      ce_n = op_ce_n;
      oe_n = op_oe_n;
      addr = op_addr;
      if (op_wr) begin
        // step 0 address, 1 enable low, 2 data on, 3 enable high with data held
        we_n      = !(step == 2'd1 || step == 2'd2);
        dq_oe     = step[1];
        dq_out    = step[1] ? op_data : '0;
        hold_step = step == 2'd3;
      end else begin
        sample_step = step == 2'd1;
      end
    end
  end
endmodule

// File: rtl/sram_result.sv
module sram_result
  import sram_tester_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic              sample_strobe,
  input  logic              finish_ok,
  input  phase_t            phase,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  input  logic [DATA_W-1:0] op_mask,
  input  logic [DATA_W-1:0] dq_in,
  output logic              mismatch,
  output logic              done,
  output logic              fail,
  output phase_t            fail_phase,
  output logic [ADDR_W-1:0] fail_addr
);
  assign mismatch = sample_strobe && byte_miscompare(dq_in, op_data, op_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      fail       <= 1'b0;
      fail_phase <= PH_NONE;
      fail_addr  <= '0;
    end else if (start_ok) begin
      done       <= 1'b0;
      fail       <= 1'b0;
      fail_phase <= PH_NONE;
      fail_addr  <= '0;
    end else if (mismatch) begin
      done       <= 1'b1;
      fail       <= 1'b1;
      fail_phase <= phase;
      fail_addr  <= op_addr;
    end else if (finish_ok) begin
      done <= 1'b1;
    end
  end
endmodule

// File: rtl/sram_tester.sv
module sram_tester
  import sram_tester_pkg::*;
#(
  parameter int                STEP_CYCLES = 2,
  parameter logic [ADDR_W-1:0] CHK_ADDR    = 11'h03F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in,
  output logic              done,
  output logic              fail,
  output logic [2:0]        fail_phase,
  output logic [ADDR_W-1:0] fail_addr
);
  logic              running;
  logic              start_ok;
  logic              step_last;
  logic              mismatch;
  logic              finish_ok;
  logic              hold_step;
  logic              sample_step;
  logic              sample_strobe;
  phase_t            phase;
  logic [1:0]        step;
  logic              op_wr;
  logic              op_ce_n;
  logic              op_oe_n;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic [DATA_W-1:0] op_mask;

  assign sample_strobe = sample_step && step_last;

  sram_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (running),
    .clear     (start_ok),
    .step_last (step_last)
  );

  sram_seq_ctrl #(.CHK_ADDR(CHK_ADDR)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .step_last (step_last),
    .mismatch  (mismatch),
    .running   (running),
    .start_ok  (start_ok),
    .phase     (phase),
    .step      (step),
    .op_wr     (op_wr),
    .op_ce_n   (op_ce_n),
    .op_oe_n   (op_oe_n),
    .op_addr   (op_addr),
    .op_data   (op_data),
    .op_mask   (op_mask),
    .finish_ok (finish_ok)
  );

  sram_pin_drive u_pins (
    .running     (running),
    .step        (step),
    .op_wr       (op_wr),
    .op_ce_n     (op_ce_n),
    .op_oe_n     (op_oe_n),
    .op_addr     (op_addr),
    .op_data     (op_data),
    .ce_n        (ram_ce_n),
    .oe_n        (ram_oe_n),
    .we_n        (ram_we_n),
    .addr        (ram_addr),
    .dq_out      (ram_dq_out),
    .dq_oe       (ram_dq_oe),
    .hold_step   (hold_step),
    .sample_step (sample_step)
  );

  sram_result u_res (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_ok      (start_ok),
    .sample_strobe (sample_strobe),
    .finish_ok     (finish_ok),
    .phase         (phase),
    .op_addr       (op_addr),
    .op_data       (op_data),
    .op_mask       (op_mask),
    .dq_in         (ram_dq_in),
    .mismatch      (mismatch),
    .done          (done),
    .fail          (fail),
    .fail_phase    (fail_phase),
    .fail_addr     (fail_addr)
  );
endmodule

// File: rtl/sram_tester_chk.sv
module sram_tester_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        running,
  input logic        hold_step,
  input logic        sample_strobe,
  input logic        mismatch,
  input logic        ce_n,
  input logic        oe_n,
  input logic        we_n,
  input logic [10:0] addr,
  input logic        dq_oe,
  input logic        done,
  input logic        fail,
  input logic [2:0]  fail_phase,
  input logic [10:0] fail_addr
);
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!ce_n && !oe_n && we_n && !dq_oe && addr == 11'd0));

  p_we_rise_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> dq_oe);

  p_release_late_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> we_n);

  p_sample_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> (!dq_oe && we_n));

  p_we_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |=> !we_n);

  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> (!running && done && fail));

  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(fail) && $stable(fail_phase) && $stable(fail_addr)));

  p_drive_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!we_n || hold_step));

  p_pass_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> fail_phase == 3'd0);
endmodule

bind sram_tester sram_tester_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .running       (running),
  .hold_step     (hold_step),
  .sample_strobe (sample_strobe),
  .mismatch      (mismatch),
  .ce_n          (ram_ce_n),
  .oe_n          (ram_oe_n),
  .we_n          (ram_we_n),
  .addr          (ram_addr),
  .dq_oe         (ram_dq_oe),
  .done          (done),
  .fail          (fail),
  .fail_phase    (fail_phase),
  .fail_addr     (fail_addr)
);

// File: tb/sram_tester_tb.sv
module sram_tester_tb;
  localparam int STEP = 2;
  localparam int CHK  = 11'h03F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ce_n, oe_n, we_n, dq_oe;
  logic [10:0] addr;
  logic [7:0]  dq_out;
  logic [7:0]  dq_in;
  logic        done, fail;
  logic [2:0]  fail_phase;
  logic [10:0] fail_addr;

  // behavioural RAM with fault knobs
  logic [7:0]  mem [0:2047];
  logic [7:0]  f_st0 = 8'h00, f_st1 = 8'h00;
  logic [10:0] f_alias = 11'h000;
  logic        f_ce_ign = 1'b0, f_oe_ign = 1'b0;
  logic [7:0]  rd;

  int n_checks = 0, n_fail = 0;
  int we_falls = 0, blocked = 0, order_bad = 0, width_bad = 0;
  int we_len = 0, oe_len = 0;
  logic prev_we = 1'b1, prev_oe = 1'b0;

  always #5 clk = ~clk;

  sram_tester #(.STEP_CYCLES(STEP), .CHK_ADDR(11'(CHK))) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ram_ce_n(ce_n), .ram_oe_n(oe_n), .ram_we_n(we_n), .ram_addr(addr),
    .ram_dq_out(dq_out), .ram_dq_oe(dq_oe), .ram_dq_in(dq_in),
    .done(done), .fail(fail), .fail_phase(fail_phase), .fail_addr(fail_addr)
  );

  always @(posedge clk)
    if (!we_n && dq_oe && (!ce_n || f_ce_ign)) mem[int'(addr & ~f_alias)] <= dq_out;

  always_comb begin
    rd = (mem[int'(addr & ~f_alias)] & ~f_st0) | f_st1;
    if (!ce_n && we_n && (!oe_n || f_oe_ign)) dq_in = rd;
    else                                      dq_in = 8'hFF; // pulled up when floating
  end

  // pin protocol monitor (R2, R8, R10, R6 stimulus)
  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n && prev_we) we_falls++;
      if (!we_n && dq_oe && ce_n) blocked++;
      if (dq_oe && !prev_oe && we_n) order_bad++;
      if (we_n && !prev_we && !prev_oe) order_bad++;
      if (!dq_oe && prev_oe && !we_n) order_bad++;
      if (dq_oe && we_n && !prev_oe) order_bad++;
      if (!we_n) we_len++;
      else if (!prev_we) begin if (we_len != 2 * STEP) width_bad++; we_len = 0; end
      if (dq_oe) oe_len++;
      else if (prev_oe) begin if (oe_len != 2 * STEP) width_bad++; oe_len = 0; end
    end
    prev_we = we_n;
    prev_oe = dq_oe;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int t_addr(int i);
    return (1 << i) - 1;
  endfunction

  function automatic int t_data(int i);
    if (i <= 8) return (1 << i) - 1;
    return (255 << (i - 8)) & 255;
  endfunction

  // first fill readback that fails when address bit j is ignored
  function automatic int alias_fail(int j);
    for (int i = 0; i < 12; i++) begin
      int last = 0;
      for (int k = 0; k < 12; k++)
        if ((t_addr(k) & ~(1 << j)) == (t_addr(i) & ~(1 << j))) last = t_data(k);
      if (last != t_data(i)) return t_addr(i);
    end
    return -1;
  endfunction

  task automatic run_seq(input string req, input bit exp_fail, input int exp_ph,
                         input int exp_addr, input int exp_wr, input int exp_cyc);
    int cyc = 0;
    int wr_at_done;
    @(negedge clk);
    for (int a = 0; a < 2048; a++) mem[a] = 8'hC3;
    we_falls = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    check({req, " done"}, int'(done), 1);
    check({req, " fail"}, int'(fail), int'(exp_fail));
    check({req, " phase"}, int'(fail_phase), exp_ph);
    if (exp_fail) check({req, " addr"}, int'(fail_addr), exp_addr);
    check({req, " writes"}, we_falls, exp_wr);
    if (exp_cyc > 0) check({req, " cycles"}, cyc, exp_cyc);
    wr_at_done = we_falls;
    repeat (6) @(negedge clk);
    check({req, " R9 stopped"}, we_falls, wr_at_done);
    check({req, " R9 held"}, int'({done, fail, fail_phase}), int'({1'b1, exp_fail, 3'(exp_ph)}));
    check({req, " R1 idle pins"}, int'({ce_n, oe_n, we_n, dq_oe, addr}), int'({4'b0010, 11'd0}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int writes, reads;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset pins", int'({ce_n, oe_n, we_n, dq_oe, addr}), int'({4'b0010, 11'd0}));
    check("R1 reset flags", int'({done, fail}), 0);

    // R5 R8 R11 healthy run: line 16w/16r, fill 12w/12r, ce 2w/1r, oe 1w/1r
    writes = 16 + 12 + 2 + 1;
    reads  = 16 + 12 + 1 + 1;
    run_seq("R11 clean", 1'b0, 0, 0, writes, (4 * writes + 2 * reads) * STEP);
    for (int i = 0; i < 12; i++)
      check("R5 fill content", int'(mem[t_addr(i)]), (t_addr(i) == CHK) ? 0 : t_data(i));
    check("R6 blocked write attempted", int'(blocked > 0), 1);
    check("R2 R10 pin order", order_bad, 0);
    check("R8 pulse widths", width_bad, 0);

    // R3 R4 stuck read bits on each line
    for (int k = 0; k < 8; k++) begin
      f_st1 = 8'(1 << k);
      run_seq("R4 stuck1", 1'b1, 1, 0, 2 * k + 1, 0);
      f_st1 = 8'h00;
      f_st0 = 8'(1 << k);
      run_seq("R4 stuck0", 1'b1, 1, 0, 2 * k + 2, 0);
      f_st0 = 8'h00;
    end

    // R5 R9 address bit ignored
    for (int j = 0; j < 11; j++) begin
      f_alias = 11'(1 << j);
      run_seq("R5 alias", 1'b1, 2, alias_fail(j), 16 + 12, 0);
    end
    f_alias = 11'h000;

    // R6 RAM that ignores chip enable
    f_ce_ign = 1'b1;
    run_seq("R6 ce ignored", 1'b1, 3, CHK, 16 + 12 + 2, 0);
    f_ce_ign = 1'b0;

    // R7 RAM that ignores output enable
    f_oe_ign = 1'b1;
    run_seq("R7 oe ignored", 1'b1, 4, CHK, 16 + 12 + 2 + 1, 0);
    f_oe_ign = 1'b0;

    // R9 a new start clears the latched failure
    run_seq("R9 rerun clean", 1'b0, 0, 0, writes, (4 * writes + 2 * reads) * STEP);
    check("R2 R10 pin order final", order_bad, 0);
    check("R8 pulse widths final", width_bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule